// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Threshold

This block selects which interrupt source one target context should service next. Each cycle it takes a pending vector, an in-service vector and an enable vector, with one bit per source. It also takes a priority field for each source and the threshold that belongs to the context. From these it produces an interrupt-request level and the identifier of the winning source. Identifier 0 is reserved and means that no interrupt is offered.

A source competes only if it is pending, enabled, not in service, and its priority is strictly above the threshold. The highest priority wins. When priorities are equal, the smaller identifier wins. The block holds no pending or in-service state and decodes no bus accesses. A controller that serves several contexts instantiates one copy per context.

The selection is a balanced tree of two-input comparators. By default an output register follows the tree, so the result is presented one clock after the inputs. The parameter `OUT_REG` can remove this register. The inputs and outputs are plain levels, with no handshake: the result is recomputed on every clock and is always valid.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A source is a candidate only when its pending bit is 1, its enable bit is 1 and its in-service bit is 0. A source that fails any of these three conditions is never reported.
- R2: A candidate is reported only if its priority is strictly greater than `thresh`. A priority equal to the threshold does not qualify.
- R3: `irq_id` is the identifier of the candidate with the highest priority among all qualifying candidates.
- R4: When several qualifying candidates share the highest priority, the one with the lowest identifier is reported.
- R5: When no source qualifies, `irq_id` is 0 and `irq_req` is 0.
- R6: A source with priority 0 is never reported, whatever the threshold.
- R7: Source n uses bit n of each flat vector, which is bit n mod 32 of 32-bit word n/32. Its priority is the 3-bit field `prio_vec[3n+2:3n]`. The highest source, `NUM_SRC` (63 by default), can be selected.
- R8: Source 0 is never reported, whatever its vector bits and priority.
- R9: `irq_req` is 1 exactly when `irq_id` is non-zero.
- R10: With `OUT_REG`=1, which is the default, the outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_vec | input | 32*ceil((NUM_SRC+1)/32) | Pending bit per source |
| en_vec | input | 32*ceil((NUM_SRC+1)/32) | Enable bit per source for this context |
| busy_vec | input | 32*ceil((NUM_SRC+1)/32) | In-service bit per source |
| prio_vec | input | 3*(NUM_SRC+1) | Priority field per source |
| thresh | input | 3 | Context threshold |
| irq_req | output | 1 | Interrupt request level |
| irq_id | output | ceil(log2(NUM_SRC+1)) | Winning source identifier, 0 when none |

## Verification
The assertions assume that every input bit is a known 0 or 1 on each rising edge. They also assume that vector bits above `NUM_SRC` are don't-care padding. The stimulus respects both assumptions: it drives every input from the bench at the falling edge and never leaves an input floating. It changes inputs only while the clock is low, so a registered result always matches exactly one set of inputs. The random patterns keep the in-service vector sparser than the pending vector, so that plenty of sources stay eligible and the tie-break and threshold comparisons get exercised.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned ARB_WORD_W = 32;
  localparam int unsigned ARB_PRIO_W = 3;
  typedef logic [ARB_PRIO_W-1:0] prio_t;

  function automatic int unsigned arb_words(input int unsigned nbits);
    return (nbits + ARB_WORD_W - 1) / ARB_WORD_W;
  endfunction
endpackage

// File: rtl/irq_arb_elig.sv
module irq_arb_elig
  import irq_arb_pkg::*;
#(
  parameter int unsigned NBITS = 64,
  parameter int unsigned VEC_W = 64
) (
  input  logic [VEC_W-1:0]            pend_vec,
  input  logic [VEC_W-1:0]            en_vec,
  input  logic [VEC_W-1:0]            busy_vec,
  input  logic [NBITS*ARB_PRIO_W-1:0] prio_vec,
  input  prio_t                       thresh,
  output logic [NBITS-1:0]            elig
);
  // Per-source mask: candidate and strictly above threshold.
  for (genvar n = 0; n < NBITS; n++) begin : g_src
    if (n == 0) begin : g_reserved
      assign elig[n] = 1'b0;
    end else begin : g_live
      prio_t pr;
      assign pr      = prio_vec[n*ARB_PRIO_W +: ARB_PRIO_W];
      assign elig[n] = pend_vec[n] & en_vec[n] & ~busy_vec[n] & (pr > thresh);
    end
  end
endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree
  import irq_arb_pkg::*;
#(
  parameter int unsigned NBITS = 64,
  parameter int unsigned IDW   = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NBITS-1:0]            elig,
  input  logic [NBITS*ARB_PRIO_W-1:0] prio_vec,
  output logic                        win_vld,
  output logic [IDW-1:0]              win_id
);
  localparam int unsigned LEAVES = 1 << IDW;
  localparam int unsigned NODES  = 2 * LEAVES;

  logic           vld [1:NODES-1];
  prio_t          pr  [1:NODES-1];
  logic [IDW-1:0] id  [1:NODES-1];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < NBITS) begin : g_used
      assign vld[LEAVES+k] = elig[k];
      assign pr[LEAVES+k]  = prio_vec[k*ARB_PRIO_W +: ARB_PRIO_W];
      assign id[LEAVES+k]  = IDW'(k);
    end else begin : g_pad
      assign vld[LEAVES+k] = 1'b0;
      assign pr[LEAVES+k]  = '0;
      assign id[LEAVES+k]  = '0;
    end
  end

  // Left child carries lower identifiers; the right one wins only when strictly higher.
  for (genvar i = 1; i < LEAVES; i++) begin : g_node
    logic take_r;
    assign take_r = vld[2*i+1] & (~vld[2*i] | (pr[2*i+1] > pr[2*i]));
    assign vld[i] = vld[2*i] | vld[2*i+1];
    assign pr[i]  = take_r ? pr[2*i+1] : pr[2*i];
    assign id[i]  = take_r ? id[2*i+1] : id[2*i];

    a_r3_node_beats_left: assert property (@(posedge clk) disable iff (!rst_n)
      vld[2*i] |-> (vld[i] && pr[i] >= pr[2*i]));
    a_r3_node_beats_right: assert property (@(posedge clk) disable iff (!rst_n)
      vld[2*i+1] |-> (vld[i] && pr[i] >= pr[2*i+1]));
    a_r4_node_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
      (vld[2*i] && vld[2*i+1] && pr[2*i] == pr[2*i+1]) |-> id[i] == id[2*i]);
  end

  assign win_vld = vld[1];
  assign win_id  = id[1];
endmodule

// File: rtl/irq_arb_outreg.sv
module irq_arb_outreg #(
  parameter int unsigned IDW = 6,
  parameter bit          EN  = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_d,
  input  logic [IDW-1:0] id_d,
  output logic           req_q,
  output logic [IDW-1:0] id_q
);
  if (EN) begin : g_flop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_q <= 1'b0;
        id_q  <= '0;
      end else begin
        req_q <= req_d;
        id_q  <= id_d;
      end
    end
  end else begin : g_wire
    assign req_q = req_d;
    assign id_q  = id_d;
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_SRC = 63,
  parameter bit          OUT_REG = 1'b1,
  localparam int unsigned NBITS  = NUM_SRC + 1,
  localparam int unsigned VEC_W  = arb_words(NBITS) * ARB_WORD_W,
  localparam int unsigned IDW    = $clog2(NBITS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [VEC_W-1:0]            pend_vec,
  input  logic [VEC_W-1:0]            en_vec,
  input  logic [VEC_W-1:0]            busy_vec,
  input  logic [NBITS*ARB_PRIO_W-1:0] prio_vec,
  input  logic [ARB_PRIO_W-1:0]       thresh,
  output logic                        irq_req,
  output logic [IDW-1:0]              irq_id
);
  logic [NBITS-1:0] elig;
  logic             win_vld;
  logic [IDW-1:0]   win_id;
  logic [IDW-1:0]   id_d;

  irq_arb_elig #(.NBITS(NBITS), .VEC_W(VEC_W)) u_elig (
    .pend_vec(pend_vec), .en_vec(en_vec), .busy_vec(busy_vec),
    .prio_vec(prio_vec), .thresh(thresh), .elig(elig)
  );

  irq_arb_tree #(.NBITS(NBITS), .IDW(IDW)) u_tree (
    .clk(clk), .rst_n(rst_n), .elig(elig), .prio_vec(prio_vec),
    .win_vld(win_vld), .win_id(win_id)
  );

  assign id_d = win_vld ? win_id : '0;

  irq_arb_outreg #(.IDW(IDW), .EN(OUT_REG)) u_out (
    .clk(clk), .rst_n(rst_n), .req_d(win_vld), .id_d(id_d),
    .req_q(irq_req), .id_q(irq_id)
  );

  // Inputs aligned with the presented result, used only by the checks below.
  logic [VEC_W-1:0]            cand_al;
  logic [NBITS*ARB_PRIO_W-1:0] prio_al;
  logic [ARB_PRIO_W-1:0]       thr_al;
  if (OUT_REG) begin : g_al_q
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cand_al <= '0;
        prio_al <= '0;
        thr_al  <= '0;
      end else begin
        cand_al <= pend_vec & en_vec & ~busy_vec;
        prio_al <= prio_vec;
        thr_al  <= thresh;
      end
    end
  end else begin : g_al_c
    assign cand_al = pend_vec & en_vec & ~busy_vec;
    assign prio_al = prio_vec;
    assign thr_al  = thresh;
  end

  a_r9_req_tracks_id: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_id != '0));
  a_r1_winner_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id != '0) |-> cand_al[irq_id]);
  a_r2_winner_above_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id != '0) |-> (prio_al[int'(irq_id)*ARB_PRIO_W +: ARB_PRIO_W] > thr_al));
  a_r6_winner_nonzero_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id != '0) |-> (prio_al[int'(irq_id)*ARB_PRIO_W +: ARB_PRIO_W] != '0));
endmodule

// File: tb/irq_prio_arbiter_test.sv
`timescale 1ns/1ps
module irq_prio_arbiter_test;
  localparam int NSRC = 63;
  localparam int NB   = NSRC + 1;
  localparam int VW   = 64;
  localparam int IW   = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [VW-1:0] pend = '0, en = '0, busy = '0;
  logic [NB*3-1:0] prio = '0;
  logic [2:0]    thr = '0;
  logic          irq_req;
  logic [IW-1:0] irq_id;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_arbiter uut (
    .clk(clk), .rst_n(rst_n), .pend_vec(pend), .en_vec(en), .busy_vec(busy),
    .prio_vec(prio), .thresh(thr), .irq_req(irq_req), .irq_id(irq_id)
  );

  function automatic int model();
    int best = 0;
    int bp = int'(thr);
    for (int n = 1; n < NB; n++) begin
      if (pend[n] && en[n] && !busy[n] && int'(prio[n*3 +: 3]) > bp) begin
        best = n;
        bp = int'(prio[n*3 +: 3]);
      end
    end
    return best;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Inputs are set at a falling edge; result is sampled one full clock later.
  task automatic go(string tag);
    int e;
    e = model();
    @(negedge clk);
    chk(tag, int'(irq_id), e);
    chk("R9 req", int'(irq_req), (e != 0) ? 1 : 0);
  endtask

  task automatic clr();
    pend = '0; en = '0; busy = '0; prio = '0; thr = '0;
  endtask

  task automatic src(int n, int p);
    pend[n] = 1'b1; en[n] = 1'b1; prio[n*3 +: 3] = 3'(p);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: reset state, with stimulus present during reset
    src(3, 5);
    repeat (3) @(negedge clk);
    chk("R10 reset id", int'(irq_id), 0);
    chk("R10 reset req", int'(irq_req), 0);
    rst_n = 1'b1;
    clr();
    go("R5 all idle");

    src(5, 3);                    go("R1 single candidate");
    busy[5] = 1'b1;               go("R1 in-service blocked");
    busy[5] = 1'b0; en[5] = 1'b0; go("R1 disabled blocked");
    en[5] = 1'b1; pend[5] = 1'b0; go("R1 not pending");
    pend[5] = 1'b1; thr = 3;      go("R2 equal to threshold");
    thr = 2;                      go("R2 above threshold");
    thr = 7;                      go("R5 threshold max");

    clr(); src(10, 4); src(40, 6); go("R3 higher wins across words");
    src(20, 7);                    go("R3 new best");
    clr(); src(12, 5); src(7, 5); src(50, 5); go("R4 tie lowest id");
    busy[7] = 1'b1;                           go("R4 tie next lowest");
    clr();
    for (int n = 1; n < NB; n++) src(n, 0);
    go("R6 zero priority never wins");
    clr(); src(0, 7); busy[0] = 1'b0; go("R8 source zero ignored");
    clr(); src(63, 1);               go("R7 top source");
    clr(); src(32, 2); src(31, 2);   go("R7 word boundary tie");

    // R10 latency: result follows a change one clock later
    clr(); src(9, 4); go("R10 follow change");
    pend[9] = 1'b0;   go("R10 follow release");

    // R3 random patterns
    for (int t = 0; t < 400; t++) begin
      pend = {$urandom, $urandom};
      en   = {$urandom, $urandom} | {$urandom, $urandom};
      busy = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      for (int n = 0; n < NB; n++) prio[n*3 +: 3] = 3'($urandom_range(0, 7));
      thr = 3'($urandom_range(0, 6));
      go("R3 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule